// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models the control side of a single-clock synchronous burst SRAM. At every rising clock edge it samples three chip enables, a sleep request, a processor address strobe, a controller address strobe, a burst-advance input and a set of write qualifiers. From these it decodes one cycle type: sleep, deselect, begin burst (processor strobe), begin burst (controller strobe), continue burst or suspend burst. It keeps a two-bit burst counter over a registered base address, holds a small word array with per-byte-lane write masking, and drives a data bus whose output enable is gated without a register by an asynchronous enable pin.

The processor strobe always opens a read and is disregarded while the first chip enable is high. A write can start only from the controller strobe or on a later burst clock. The data bus pad itself sits in the I/O ring. This block supplies the output word, a drive enable and the sampled input word.

A small state machine records the last sampled cycle. Its states are `ST_IDLE` (no burst open, reached from reset, deselect, or a continue or suspend with no burst open), `ST_SLEEP` (sleep sampled), `ST_READ` (a read access taken at the last edge) and `ST_WRITE` (a write access taken at the last edge). The transitions are named by the decoded cycle: `CYC_SLEEP` goes to `ST_SLEEP` from any state, and `CYC_DESEL` goes to `ST_IDLE`. `CYC_BEGIN_P` goes to `ST_READ`. `CYC_BEGIN_C` goes to `ST_WRITE` or `ST_READ`. `CYC_CONT` and `CYC_SUSP` go from `ST_READ` or `ST_WRITE` to `ST_READ` or `ST_WRITE` according to the write qualifiers, and from `ST_IDLE` or `ST_SLEEP` to `ST_IDLE`.

Top module: `sbsram_ctrl`

## Requirements
- R1: After reset the data bus drive enable is low and no burst is open.
- R2: When the first enable (`ce1_n`) is high and the controller strobe is low, a deselect is sampled whatever the processor strobe is. The bus is released and the open burst ends, so a following continue cycle drives nothing.
- R3: When `ce1_n` is low, and either `ce2` is low or `ce3_n` is high, and either strobe is low, a deselect is sampled. No array write occurs and the bus is released.
- R4: While `sleep` is high, all other inputs have no effect. No write occurs, the bus is released, and the burst ends.
- R5: With the chip selected, a low processor strobe begins a burst at `addr` and always reads, even when `gw_n` is low. The array is left unchanged.
- R6: With the chip selected, the processor strobe high and the controller strobe low, a burst begins at `addr`. It writes `dq_i` when the internal write is active and reads otherwise.
- R7: When both strobes are high and `adv_n` is low, the access moves to the next burst address. With `burst_mode`=0 the two low address bits count up by one modulo 4 from the start (start 2 gives 2,3,0,1), and the upper bits stay fixed.
- R8: With `burst_mode`=1 the low two bits are the start bits XOR the count (start 1 gives 1,0,3,2).
- R9: When both strobes are high and `adv_n` is high, the access repeats at the current burst address, as a read or a write.
- R10: While `ce1_n` is high, a low processor strobe is ignored. With the controller strobe high, the cycle continues or suspends the burst.
- R11: The internal write is active when `gw_n` is low, which writes all lanes. It is also active when `bwe_n` is low and at least one bit of `bw_n` is low. Then only the lanes whose `bw_n` bit is low are written, with lane k at bits [8k+7:8k]. With `bwe_n` low and all `bw_n` high, the cycle is a read.
- R12: Read data appears on `dq_o` with `dq_oe` high in the clock period after the edge that samples the read cycle. `dq_oe` follows `oe_n` without waiting for a clock edge.
- R13: After a write cycle `dq_oe` stays low even when `oe_n` is low.
- R14: A continue or suspend cycle with no burst open performs no access and leaves the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| sleep | input | 1 | Sleep request, active high |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_mode | input | 1 | 0 linear, 1 interleaved burst order |
| addr | input | ADDR_W | External word address |
| dq_i | input | LANES*LANE_W | Write data sampled from the bus |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A wrong state register shows up in the first period after the faulty edge. The bus is then driven after a write, a deselect or sleep, or it stays released after a read. A burst counter that steps wrongly or fails to hold puts the wrong stored word on `dq_o` one period after the continue or suspend edge. A wrong lane mask or a write that should have been suppressed stays hidden until that address is read back. For this reason the directed tests read back every address they could have corrupted.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL,
        CYC_SLEEP,
        CYC_BEGIN_P,
        CYC_BEGIN_C,
        CYC_CONT,
        CYC_SUSP
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_READ,
        ST_WRITE
    } st_e;

    // low two address bits for a burst step
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             sleep,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output cyc_e             cyc,
    output logic             wr,
    output logic [LANES-1:0] lane_we
);

    logic aux_ok;

    always_comb begin
        aux_ok  = ce2 && !ce3_n;
        wr      = !gw_n || (!bwe_n && !(&bw_n));
        lane_we = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);

        // priority order of the cycle decode
        if (sleep)
            cyc = CYC_SLEEP;
        else if (ce1_n && !adsc_n)
            cyc = CYC_DESEL;
        else if (!ce1_n && !aux_ok && (!adsp_n || !adsc_n))
            cyc = CYC_DESEL;
        else if (!ce1_n && !adsp_n)
            cyc = CYC_BEGIN_P;
        else if (!adsc_n)
            cyc = CYC_BEGIN_C;
        else if (!adv_n)
            cyc = CYC_CONT;
        else
            cyc = CYC_SUSP;
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              cyc,
    input  logic              open_q,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] op_addr,
    output logic [1:0]        cnt
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [ADDR_W-1:0] eff_base;
    logic [1:0]        eff_cnt;
    logic              is_begin;
    logic              do_step;

    always_comb begin
        is_begin = (cyc == CYC_BEGIN_P) || (cyc == CYC_BEGIN_C);
        do_step  = (cyc == CYC_CONT) && open_q;
        eff_base = is_begin ? ext_addr : base_q;
        eff_cnt  = is_begin ? 2'd0 : (do_step ? cnt_q + 2'd1 : cnt_q);
        op_addr  = {eff_base[ADDR_W-1:2],
                    burst_offset(eff_base[1:0], eff_cnt, ilv)};
        cnt      = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (is_begin) begin
            base_q <= ext_addr;
            cnt_q  <= 2'd0;
        end else if (do_step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    re,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] wmerge;
    logic [WORD_W-1:0] rdata_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wmerge[g*LANE_W +: LANE_W] = lane_we[g] ? wdata[g*LANE_W +: LANE_W]
                                                       : mem[addr][g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wmerge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (re)
            rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    sleep,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int WORD_W = LANES * LANE_W;

    cyc_e              cyc;
    logic              wr;
    logic [LANES-1:0]  lane_we;
    st_e               state_q;
    st_e               state_d;
    logic              burst_open;
    logic [ADDR_W-1:0] op_addr;
    logic [1:0]        burst_cnt;
    logic              mem_we;
    logic              mem_re;
    logic [WORD_W-1:0] rdata;

    sbsram_decode #(.LANES(LANES)) u_dec (
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .sleep   (sleep),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .cyc     (cyc),
        .wr      (wr),
        .lane_we (lane_we)
    );

    assign burst_open = (state_q == ST_READ) || (state_q == ST_WRITE);

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc),
        .open_q   (burst_open),
        .ilv      (burst_mode),
        .ext_addr (addr),
        .op_addr  (op_addr),
        .cnt      (burst_cnt)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .re      (mem_re),
        .lane_we (lane_we),
        .addr    (op_addr),
        .wdata   (dq_i),
        .rdata   (rdata)
    );

    // next-state decision
    always_comb begin
        unique case (cyc)
            CYC_SLEEP:   state_d = ST_SLEEP;
            CYC_DESEL:   state_d = ST_IDLE;
            CYC_BEGIN_P: state_d = ST_READ;
            CYC_BEGIN_C: state_d = wr ? ST_WRITE : ST_READ;
            CYC_CONT,
            CYC_SUSP:    state_d = burst_open ? (wr ? ST_WRITE : ST_READ) : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs and array strobes
    always_comb begin
        mem_we = (state_d == ST_WRITE);
        mem_re = (state_d == ST_READ);
        dq_oe  = (state_q == ST_READ) && !oe_n;
        dq_o   = rdata;
    end

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce1_n,
    input logic             ce2,
    input logic             ce3_n,
    input logic             sleep,
    input logic             adsp_n,
    input logic             adsc_n,
    input logic             adv_n,
    input logic             gw_n,
    input logic             bwe_n,
    input logic [LANES-1:0] bw_n,
    input st_e              state,
    input logic [1:0]       cnt,
    input logic             dq_oe
);

    logic wr_any;
    logic on_chip;
    logic plain_cyc;
    logic active;

    assign wr_any    = !gw_n || (!bwe_n && !(&bw_n));
    assign on_chip   = !ce1_n && ce2 && !ce3_n;
    assign plain_cyc = !sleep && adsc_n && (adsp_n || ce1_n);
    assign active    = (state == ST_READ) || (state == ST_WRITE);

    p_sleep_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!dq_oe && state == ST_SLEEP));

    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ce1_n && !adsc_n) |=> (!dq_oe && state == ST_IDLE));

    p_adsp_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && on_chip && !adsp_n) |=> (state == ST_READ));

    p_write_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && on_chip && adsp_n && !adsc_n && wr_any) |=> (!dq_oe && state == ST_WRITE));

    p_cont_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_cyc && !adv_n && active) |=> (cnt == $past(cnt) + 2'd1));

    p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_cyc && adv_n) |=> $stable(cnt));

    p_idle_stay_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_cyc && !active) |=> (state == ST_IDLE && !dq_oe));

endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .sleep  (sleep),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .adv_n  (adv_n),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .state  (state_q),
    .cnt    (burst_cnt),
    .dq_oe  (dq_oe)
);

// File: tb/sbsram_ctrl_tb.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb;

    localparam int AW = 8;
    localparam int NL = 2;
    localparam int LW = 8;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce1_n, ce2, ce3_n, sleep;
    logic          adsp_n, adsc_n, adv_n;
    logic          gw_n, bwe_n;
    logic [NL-1:0] bw_n;
    logic          oe_n, burst_mode;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_i;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sbsram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .sleep(sleep), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .burst_mode(burst_mode), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_idle();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; sleep = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b1;
        addr = '0; dq_i = '0;
    endtask

    task automatic wr_begin(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_idle(); adsc_n = 1'b0; gw_n = 1'b0; addr = a; dq_i = d; tick();
    endtask

    task automatic wr_next(input logic [DW-1:0] d);
        set_idle(); adv_n = 1'b0; gw_n = 1'b0; dq_i = d; tick();
    endtask

    task automatic rd_begin(input logic [AW-1:0] a);
        set_idle(); adsp_n = 1'b0; addr = a; oe_n = 1'b0; tick();
    endtask

    task automatic rd_next();
        set_idle(); adv_n = 1'b0; oe_n = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", dq_oe, 0);
        set_idle(); adv_n = 1'b0; oe_n = 1'b0; tick();
        chk("R14 continue with no burst", dq_oe, 0);
        set_idle(); oe_n = 1'b0; tick();
        chk("R14 suspend with no burst", dq_oe, 0);
    endtask

    task automatic t_linear();
        wr_begin(8'd6, 16'h1111);
        wr_next(16'h2222);
        wr_next(16'h3333);
        wr_next(16'h4444);
        rd_begin(8'd6);
        chk("R6 write at start 6", dq_o, 16'h1111);
        chk("R12 drive after read", dq_oe, 1);
        rd_next(); chk("R7 step to 7", dq_o, 16'h2222);
        rd_next(); chk("R7 wrap to 4", dq_o, 16'h3333);
        rd_next(); chk("R7 step to 5", dq_o, 16'h4444);
        rd_next(); chk("R7 wrap back to 6", dq_o, 16'h1111);
        set_idle(); adsc_n = 1'b0; addr = 8'd4; oe_n = 1'b0; tick();
        chk("R6 controller strobe read", dq_o, 16'h3333);
    endtask

    task automatic t_interleave();
        burst_mode = 1'b1;
        wr_begin(8'd9, 16'hA0A0);
        wr_next(16'hA1A1);
        wr_next(16'hA2A2);
        wr_next(16'hA3A3);
        burst_mode = 1'b0;
        rd_begin(8'd9);  chk("R8 word at 9", dq_o, 16'hA0A0);
        rd_begin(8'd8);  chk("R8 word at 8", dq_o, 16'hA1A1);
        rd_begin(8'd11); chk("R8 word at 11", dq_o, 16'hA2A2);
        rd_begin(8'd10); chk("R8 word at 10", dq_o, 16'hA3A3);
    endtask

    task automatic t_suspend();
        rd_begin(8'd6);
        set_idle(); oe_n = 1'b0; tick();
        chk("R9 suspend read holds 6", dq_o, 16'h1111);
        set_idle(); gw_n = 1'b0; dq_i = 16'h5555; oe_n = 1'b0; tick();
        chk("R13 no drive after write", dq_oe, 0);
        rd_begin(8'd6);
        chk("R9 suspend write hit 6", dq_o, 16'h5555);
    endtask

    task automatic t_bytes();
        wr_begin(8'd20, 16'hAAAA);
        set_idle(); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10; addr = 8'd20;
        dq_i = 16'h1234; tick();
        set_idle(); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b11; addr = 8'd20;
        dq_i = 16'h9999; oe_n = 1'b0; tick();
        chk("R11 no lanes means read", dq_oe, 1);
        chk("R11 lane 0 only", dq_o, 16'hAA34);
        set_idle(); adsp_n = 1'b0; gw_n = 1'b0; addr = 8'd20; dq_i = 16'hFFFF;
        oe_n = 1'b0; tick();
        chk("R5 processor strobe reads", dq_o, 16'hAA34);
        set_idle(); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b01; addr = 8'd20;
        dq_i = 16'h5600; tick();
        rd_begin(8'd20);
        chk("R11 lane 1 only", dq_o, 16'h5634);
    endtask

    task automatic t_oe();
        rd_begin(8'd4);
        chk("R12 drive on", dq_oe, 1);
        oe_n = 1'b1; #1;
        chk("R12 async release", dq_oe, 0);
        oe_n = 1'b0; #1;
        chk("R12 async drive", dq_oe, 1);
        wr_begin(8'd21, 16'h7777);
        set_idle(); adsp_n = 1'b0; addr = 8'd21; oe_n = 1'b0; #1;
        chk("R12 not before edge", dq_oe, 0);
        tick();
        chk("R12 data one clock later", dq_o, 16'h7777);
    endtask

    task automatic t_desel();
        rd_begin(8'd6);
        set_idle(); ce1_n = 1'b1; adsc_n = 1'b0; adsp_n = 1'b0; oe_n = 1'b0; tick();
        chk("R2 deselect releases", dq_oe, 0);
        set_idle(); adv_n = 1'b0; oe_n = 1'b0; tick();
        chk("R2 burst ended", dq_oe, 0);
        rd_begin(8'd6);
        set_idle(); ce2 = 1'b0; adsp_n = 1'b0; oe_n = 1'b0; tick();
        chk("R3 ce2 low deselect", dq_oe, 0);
        rd_begin(8'd6);
        set_idle(); ce3_n = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd6;
        dq_i = 16'h0BAD; oe_n = 1'b0; tick();
        chk("R3 ce3 high deselect", dq_oe, 0);
        rd_begin(8'd6);
        chk("R3 no write while deselected", dq_o, 16'h5555);
    endtask

    task automatic t_ce1_ignore();
        rd_begin(8'd6);
        set_idle(); ce1_n = 1'b1; adsp_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0; tick();
        chk("R10 strobe ignored drive", dq_oe, 1);
        chk("R10 continued to 7", dq_o, 16'h2222);
    endtask

    task automatic t_sleep();
        rd_begin(8'd6);
        set_idle(); sleep = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd6;
        dq_i = 16'h0BAD; oe_n = 1'b0; tick();
        chk("R4 sleep releases", dq_oe, 0);
        set_idle(); adv_n = 1'b0; oe_n = 1'b0; tick();
        chk("R4 burst ended by sleep", dq_oe, 0);
        rd_begin(8'd6);
        chk("R4 no write in sleep", dq_o, 16'h5555);
    endtask

    initial begin
        set_idle();
        burst_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_interleave();
        t_suspend();
        t_bytes();
        t_oe();
        t_desel();
        t_ce1_ignore();
        t_sleep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule